// File: doc/BRIEF.md
# Framed Register-Write Command Decoder

This block sits behind a byte-wide serial receiver. It turns command frames into register write strobes for a write-only register space. A frame opens with the five bytes 0x40, 0x4C, 0x44, 0x53, 0x7E. Any number of two-byte payload words follow, each sent high byte first, and a single 0x7E byte closes the frame. Every payload word is one register write: a 4-bit address and an 8-bit value. Two check bits hold inverted copies of value bits 5 and 7, so the framing byte 0x7E can never appear in either byte of a valid word.

The decoder keeps an 8-bit bank-select register, loaded by any write to address 15. The bank changes how downstream logic reads the low addresses. Each accepted write appears on the output as a one-cycle strobe carrying the address, the value and the bank in force when the write was decoded. A write to address 15 is also passed downstream. Nothing can be read back. The byte input always accepts data.

Top module: `cmd_frame_decoder`

## Requirements
- R1: Payload bytes are decoded only after the full opening sequence 0x40, 0x4C, 0x44, 0x53, 0x7E; bytes outside a frame never produce a write.
- R2: A byte that does not match the expected opening byte sends the parser back to hunting for 0x40; if that byte is itself 0x40, matching restarts from the second opening byte.
- R3: A payload word w (high byte first) writes address w[11:8] with value {w[13:12], w[5:0]}; the strobe rises in the cycle after the low byte is accepted.
- R4: A word is valid only if w[15]=0, w[7]=0, w[14] is the inverse of value bit 7 and w[6] is the inverse of value bit 5. An invalid word produces no write, and every later word of that frame is discarded until the next 0x7E.
- R5: 0x7E in the high-byte position ends the frame cleanly; later bytes need a new opening sequence.
- R6: 0x7E in the low-byte position aborts the frame without any write for the partial word.
- R7: A write to address 15 loads the bank register with its value and is also issued downstream carrying the previous bank. Later writes, in the same or later frames, carry the new bank. The bank resets to 0.
- R8: in_ready is always 1, and cycles with in_valid low change nothing.
- R9: The write strobe lasts exactly one cycle per accepted word and is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on in_data is present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Decoder accepts a byte (always 1) |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_bank | output | 8 | Bank in force when the write was decoded |
| wr_addr | output | 4 | Register address of the write |
| wr_data | output | 8 | Register value of the write |

## Verification
The hardest situations to reach are a frame that stays in the discard state after a bad word, and a header match that restarts on a stray 0x40. Both depend on exact byte orderings that arbitrary traffic seldom produces. The bench builds these orderings directly: it corrupts single check or reserved bits in encoded words and follows them with valid words in the same frame, and it places 0x40 and 0x7E bytes at chosen header and payload positions. A full sweep of every address and value, including the bank-select address, covers the field mapping and the carrying of the bank from one frame to the next.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int HDR_LEN = 5;
    localparam int IDX_W   = $clog2(HDR_LEN);

    localparam logic [BYTE_W-1:0] FRAME_MARK = 8'h7E;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_HDR,
        ST_HI,
        ST_LO,
        ST_SKIP
    } pstate_e;

    // opening sequence byte at position i
    function automatic logic [BYTE_W-1:0] hdr_byte(input logic [IDX_W-1:0] i);
        case (i)
            3'd0:    hdr_byte = 8'h40;
            3'd1:    hdr_byte = 8'h4C;
            3'd2:    hdr_byte = 8'h44;
            3'd3:    hdr_byte = 8'h53;
            default: hdr_byte = FRAME_MARK;
        endcase
    endfunction

    typedef struct packed {
        pstate_e             st;
        logic [IDX_W-1:0]    idx;
        logic [BYTE_W-1:0]   hi;
        logic                stb;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [DATA_W-1:0]   bank;
    } parse_t;
endpackage

// File: rtl/cfd_word_unpack.sv
module cfd_word_unpack
    import cfd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              ok,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] value
);
    always_comb begin
        value = {word[13:12], word[5:0]};
        addr  = word[11:8];
        ok    = !word[15] && !word[7]
                && (word[14] != value[7])
                && (word[6]  != value[5]);
    end
endmodule

// File: rtl/cfd_bank_reg.sv
module cfd_bank_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] bank
);
    logic [W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) bank_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bank = bank_q;
endmodule

// File: rtl/cfd_frame_fsm.sv
module cfd_frame_fsm
    import cfd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BANK_ADDR = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              word_ok,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [DATA_W-1:0] word_value,
    input  logic [DATA_W-1:0] bank,
    output logic [BYTE_W-1:0] hi_byte,
    output logic              bank_we,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    parse_t q, d;
    logic   accept;
    logic   is_mark;

    assign is_mark = (in_data == FRAME_MARK);

    always_comb begin
        d      = q;
        d.stb  = 1'b0;
        accept = 1'b0;
        if (in_valid) begin
            case (q.st)
                ST_HUNT: begin
                    if (in_data == hdr_byte('0)) begin
                        d.st  = ST_HDR;
                        d.idx = IDX_W'(1);
                    end
                end
                ST_HDR: begin
                    if (in_data == hdr_byte(q.idx)) begin
                        if (q.idx == IDX_W'(HDR_LEN - 1)) d.st = ST_HI;
                        else                              d.idx = q.idx + 1'b1;
                    end else if (in_data == hdr_byte('0)) begin
                        d.idx = IDX_W'(1);
                    end else begin
                        d.st = ST_HUNT;
                    end
                end
                ST_HI: begin
                    if (is_mark) begin
                        d.st = ST_HUNT;
                    end else begin
                        d.hi = in_data;
                        d.st = ST_LO;
                    end
                end
                ST_LO: begin
                    if (is_mark) begin
                        d.st = ST_HUNT;
                    end else if (word_ok) begin
                        accept = 1'b1;
                        d.stb  = 1'b1;
                        d.addr = word_addr;
                        d.data = word_value;
                        d.bank = bank;
                        d.st   = ST_HI;
                    end else begin
                        d.st = ST_SKIP;
                    end
                end
                ST_SKIP: begin
                    if (is_mark) d.st = ST_HUNT;
                end
                default: d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hi_byte = q.hi;
    assign bank_we = accept && (word_addr == BANK_ADDR);
    assign wr_stb  = q.stb;
    assign wr_bank = q.bank;
    assign wr_addr = q.addr;
    assign wr_data = q.data;
endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
    import cfd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BANK_ADDR = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [BYTE_W-1:0] hi_byte;
    logic              word_ok;
    logic [ADDR_W-1:0] word_addr;
    logic [DATA_W-1:0] word_value;
    logic [DATA_W-1:0] bank_q;
    logic              bank_we;

    assign in_ready = 1'b1;

    cfd_word_unpack u_unpack (
        .word  ({hi_byte, in_data}),
        .ok    (word_ok),
        .addr  (word_addr),
        .value (word_value)
    );

    cfd_bank_reg #(.W(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .wdata (word_value),
        .bank  (bank_q)
    );

    cfd_frame_fsm #(.BANK_ADDR(BANK_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .word_ok    (word_ok),
        .word_addr  (word_addr),
        .word_value (word_value),
        .bank       (bank_q),
        .hi_byte    (hi_byte),
        .bank_we    (bank_we),
        .wr_stb     (wr_stb),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker
    import cfd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BANK_ADDR = 4'hF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [BYTE_W-1:0] in_data,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] bank_q
);
    p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wr_stb);

    p_low_not_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(in_data) != FRAME_MARK);

    p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> wr_data[5:0] == $past(in_data[5:0]));

    p_check_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (!$past(in_data[7]) && ($past(in_data[6]) != wr_data[5])));

    p_bank_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == BANK_ADDR) |-> bank_q == wr_data);

    p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == BANK_ADDR) |-> $stable(bank_q));
endmodule

bind cmd_frame_decoder cfd_checker #(.BANK_ADDR(BANK_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .bank_q   (bank_q)
);

// File: tb/cmd_frame_decoder_bench.sv
`timescale 1ns/1ps
module cmd_frame_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       wr_stb;
    logic [7:0] wr_bank;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;
    int mbank  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cmd_frame_decoder u_cmd_frame_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .wr_stb   (wr_stb),
        .wr_bank  (wr_bank),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    function automatic int enc(input int a, input int v);
        return (v & 'h3f) | ((v & 'hc0) << 6) | ((a & 'hf) << 8)
             | (((v ^ 'h20) & 'h20) << 1) | (((v ^ 'h80) & 'h80) << 7);
    endfunction

    // all tasks start and end at a falling edge
    task automatic chk(input bit es, input int ea, input int ed, input int eb, input string req);
        checks++;
        if (wr_stb !== es || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL %s: stb=%0b ready=%0b expected stb=%0b ready=1", req, wr_stb, in_ready, es);
        end else if (es && (wr_addr !== 4'(ea) || wr_data !== 8'(ed) || wr_bank !== 8'(eb))) begin
            errors++;
            $display("FAIL %s: addr=%0h data=%0h bank=%0h expected addr=%0h data=%0h bank=%0h",
                     req, wr_addr, wr_data, wr_bank, ea, ed, eb);
        end
    endtask

    task automatic send(input int b);
        in_valid = 1'b1;
        in_data  = 8'(b);
        @(negedge clk);
    endtask

    task automatic raw(input int b, input string req);
        send(b);
        chk(1'b0, 0, 0, 0, req);
    endtask

    task automatic idle(input int n, input int junk);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_data  = 8'(junk);
            @(negedge clk);
            chk(1'b0, 0, 0, 0, "R8 idle");
        end
    endtask

    task automatic hdr(input string req);
        raw('h40, req); raw('h4C, req); raw('h44, req); raw('h53, req); raw('h7E, req);
    endtask

    task automatic word(input int a, input int v, input string req);
        int w;
        w = enc(a, v);
        raw(w >> 8, req);
        send(w & 'hff);
        chk(1'b1, a, v, mbank, req);
        if (a == 15) mbank = v;
    endtask

    task automatic dead_word(input int a, input int v, input string req);
        int w;
        w = enc(a, v);
        raw(w >> 8, req);
        raw(w & 'hff, req);
    endtask

    initial begin
        int w;
        @(negedge clk);
        @(negedge clk);
        chk(1'b0, 0, 0, 0, "R9 reset");
        checks++;
        if (wr_bank !== 8'h00) begin
            errors++;
            $display("FAIL R7 reset bank: %0h expected 0", wr_bank);
        end
        rst_n = 1'b1;

        // R1: payload outside a frame is ignored
        dead_word(3, 'h21, "R1 no header");
        // R3/R7/R9 full sweep, bank tracked by the model
        for (int a = 0; a < 16; a++) begin
            hdr("R1 header");
            for (int v = 0; v < 256; v++) word(a, v, "R3 sweep");
            raw('h7E, "R5 close");
            idle(1, 'h40);
        end
        // R7: the bank write carries the old bank, later words the new one
        hdr("R7 header");
        word(15, 'h03, "R7 bank write");
        word(0, 'h09, "R7 new bank");
        raw('h7E, "R5 close");
        hdr("R7 header");
        word(1, 'h5A, "R7 bank persists");
        // R8: idle cycles with marker data mid-word do not abort
        w = enc(2, 'hC4);
        raw(w >> 8, "R8 hi");
        idle(4, 'h7E);
        send(w & 'hff);
        chk(1'b1, 2, 'hC4, mbank, "R8 after idle");
        // R5: clean end, following payload ignored
        raw('h7E, "R5 close");
        dead_word(2, 'h11, "R5 after end");
        // R6: abort at low byte
        hdr("R6 header");
        w = enc(2, 'h11);
        raw(w >> 8, "R6 hi");
        raw('h7E, "R6 abort");
        raw(w & 'hff, "R6 stray low");
        dead_word(4, 'h22, "R6 after abort");
        // R4: bad bit 6, then valid word in the same frame dropped
        hdr("R4 header");
        w = enc(2, 'h11);
        raw(w >> 8, "R4 hi");
        raw((w & 'hff) ^ 'h40, "R4 bad bit6");
        dead_word(5, 'h33, "R4 skip rest");
        raw('h7E, "R4 close");
        hdr("R4 header");
        word(6, 'h44, "R4 recover");
        // R4: bad bit 14
        raw(((w >> 8) ^ 'h40), "R4 bad bit14 hi");
        raw(w & 'hff, "R4 bad bit14 lo");
        dead_word(5, 'h33, "R4 skip rest");
        raw('h7E, "R4 close");
        // R4: reserved bit 15
        hdr("R4 header");
        raw((w >> 8) | 'h80, "R4 bit15 hi");
        raw(w & 'hff, "R4 bit15 lo");
        dead_word(5, 'h33, "R4 skip rest");
        raw('h7E, "R4 close");
        // R4: reserved bit 7
        hdr("R4 header");
        raw(w >> 8, "R4 bit7 hi");
        raw((w & 'hff) | 'h80, "R4 bit7 lo");
        dead_word(5, 'h33, "R4 skip rest");
        raw('h7E, "R4 close");
        // R2: mismatch with 0x40 restarts the match
        raw('h40, "R2"); raw('h4C, "R2"); raw('h40, "R2");
        raw('h4C, "R2"); raw('h44, "R2"); raw('h53, "R2"); raw('h7E, "R2");
        word(7, 'h80, "R2 restart ok");
        raw('h7E, "R5 close");
        raw('h40, "R2"); raw('h40, "R2"); raw('h4C, "R2");
        raw('h44, "R2"); raw('h53, "R2"); raw('h7E, "R2");
        word(8, 'h7F, "R2 double 40");
        raw('h7E, "R5 close");
        // R2: other mismatch falls back to hunting
        raw('h40, "R2"); raw('h4C, "R2"); raw('h44, "R2");
        raw('h00, "R2 mismatch"); raw('h53, "R2"); raw('h7E, "R2");
        dead_word(9, 'h12, "R2 hunt");
        idle(2, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule